// File: doc/BRIEF.md
# Video Preamplifier Control Register Receiver

This block is the serial control port of a video preamplifier. It listens on an I2C bus and takes only write transfers. It samples SCL and SDA with a fast system clock and answers a single fixed device address. It loads gain, black-level, cut-off and routing fields into a staging register bank. A separate commit stage copies the staged values to the analog side at a safe point. That stage watches `busy_o` so that it does not take a bank that is only half written.

A transfer starts with the device address byte and continues with a sub-address byte. The data bytes that follow land at the sub-address, and the sub-address moves forward by one after each byte. The block never returns data and never holds SCL low. It pulls SDA low only to acknowledge a byte.

Top module: `vidpre_i2c_regs`

## Requirements
- R1: The 8-bit address byte 40h (a 7-bit address of 20h with the write bit 0) is acknowledged: SDA is low during the ninth SCL pulse, and SDA changes only while SCL is low.
- R2: Any other address byte is not acknowledged. The transfer is then ignored until the next START: no further acknowledge is given and no register changes.
- R3: The first byte after a matched address is taken as the sub-address and is acknowledged. Each data byte is acknowledged and is written at the current sub-address.
- R4: After each data byte the 8-bit sub-address increments by one and wraps from FFh to 00h. A burst therefore fills consecutive registers.
- R5: The register fields are mapped as follows. Sub-addresses 00h, 02h, 03h, 04h, 06h, 07h, 08h and 09h are full 8-bit values: contrast, R/G/B cut-off, common cut-off and R/G/B sub-contrast. Sub-address 01h holds brightness in bits 5:0 and blank mode in bit 6. Sub-address 05h holds OSD gain in bits 5:0 and slice level in bit 6. Sub-address 0Ah holds detector-off in bit 7, output-source select in bit 6 (0 = sync separator, 1 = video detector) and refresh-sync disable in bit 0.
- R6: Bits that R5 does not name (bit 7 of 01h and 05h, bits 5:1 of 0Ah) are dropped on write. Writes to sub-addresses 0Bh to FFh are acknowledged but change nothing.
- R7: `busy_o` rises on START and falls on STOP. It stays high across a repeated START, and no register is written while it is low.
- R8: An address byte with the read bit set (41h) is not acknowledged, and the block never drives SDA outside an acknowledge slot of an active transfer.
- R9: Reset clears every field to zero, clears `busy_o` and releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level |
| sda_oe_o | output | 1 | 1 = pull SDA low (acknowledge) |
| busy_o | output | 1 | Transfer in progress, START to STOP |
| contrast_o | output | 8 | Common contrast |
| bright_o | output | 6 | Common brightness |
| blank_mode_o | output | 1 | Blanking level mode |
| cut_r_o | output | 8 | Red cut-off |
| cut_g_o | output | 8 | Green cut-off |
| cut_b_o | output | 8 | Blue cut-off |
| osd_gain_o | output | 6 | OSD gain |
| slice_lvl_o | output | 1 | Video-detect slice level |
| cut_all_o | output | 8 | Common cut-off |
| sub_r_o | output | 8 | Red sub-contrast |
| sub_g_o | output | 8 | Green sub-contrast |
| sub_b_o | output | 8 | Blue sub-contrast |
| det_off_o | output | 1 | Detector output off |
| src_sel_o | output | 1 | Output source select |
| refresh_dis_o | output | 1 | Refresh-sync disable |

## Verification
The bench builds the block with its defaults: device address 20h and two synchronizer stages. It runs SCL at 40 system clocks per bit, so every SDA change falls several cycles away from an SCL edge. This speed lets the bench write three data patterns (all ones, all zeros and a computed value) to each of the sixteen sub-addresses 00h to 0Fh. Those writes cover every field, every dropped bit and the unmapped range. The bench also sends full and partial bursts, including one that wraps past FFh. It drives transfers to a wrong address and to the read address, and a transfer with a repeated START.

// File: rtl/vidpre_pkg.sv
package vidpre_pkg;
  localparam int unsigned DW       = 8;
  localparam int unsigned NUM_REGS = 11;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_DATA
  } rx_state_e;

  // writable bits per sub-address
  function automatic logic [DW-1:0] reg_mask(int unsigned idx);
    case (idx)
      1:       return 8'h7F;
      5:       return 8'h7F;
      10:      return 8'hC1;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_q  <= scl_sh[STAGES-1];
      sda_q  <= sda_sh[STAGES-1];
    end
  end

  assign scl_o      = scl_sh[STAGES-1];
  assign sda_o      = sda_sh[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // SDA edges count only with SCL high on both sides of the edge
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
  import vidpre_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR = 7'h20,
  parameter int unsigned AW       = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  output logic          sda_oe_o,
  output logic          busy_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  rx_state_e     state_q;
  logic [3:0]    bit_cnt_q;
  logic [DW-1:0] shift_q;
  logic [AW-1:0] ptr_q;
  logic          ack_ph_q, oe_q, busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      shift_q   <= '0;
      ptr_q     <= '0;
      ack_ph_q  <= 1'b0;
      oe_q      <= 1'b0;
      busy_q    <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        busy_q    <= 1'b1;
        state_q   <= ST_ADDR;
        bit_cnt_q <= '0;
        ack_ph_q  <= 1'b0;
        oe_q      <= 1'b0;
      end else if (stop_i) begin
        busy_q    <= 1'b0;
        state_q   <= ST_IDLE;
        bit_cnt_q <= '0;
        ack_ph_q  <= 1'b0;
        oe_q      <= 1'b0;
      end else if (state_q != ST_IDLE) begin
        if (scl_rise_i && !ack_ph_q && bit_cnt_q < 4'd8) begin
          shift_q   <= {shift_q[DW-2:0], sda_i};
          bit_cnt_q <= bit_cnt_q + 4'd1;
        end
        if (scl_fall_i) begin
          if (ack_ph_q) begin
            ack_ph_q  <= 1'b0;
            oe_q      <= 1'b0;
            bit_cnt_q <= '0;
          end else if (bit_cnt_q == 4'd8) begin
            ack_ph_q <= 1'b1;
            case (state_q)
              ST_ADDR: begin
                if (shift_q == {DEV_ADDR, 1'b0}) begin
                  oe_q    <= 1'b1;
                  state_q <= ST_SUB;
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              ST_SUB: begin
                ptr_q   <= AW'(shift_q);
                oe_q    <= 1'b1;
                state_q <= ST_DATA;
              end
              default: begin
                oe_q      <= 1'b1;
                ptr_q     <= ptr_q + 1'b1;
                wr_en_o   <= (ptr_q < AW'(NUM_REGS));
                wr_addr_o <= ptr_q;
                wr_data_o <= shift_q;
              end
            endcase
          end
        end
      end
    end
  end

  assign sda_oe_o = oe_q;
  assign busy_o   = busy_q;

  p_oe_scl_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_q) |-> !scl_i);
  p_nack_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !oe_q);
  p_busy_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_q);
  p_busy_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!busy_q && !oe_q));
  p_idle_no_drive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !oe_q);
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
  import vidpre_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         busy_i,
  input  logic                         wr_en_i,
  input  logic [AW-1:0]                wr_addr_i,
  input  logic [DW-1:0]                wr_data_i,
  output logic [NUM_REGS-1:0][DW-1:0]  regs_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DW-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   r_q <= '0;
      else if (wr_en_i && wr_addr_i == AW'(i))       r_q <= wr_data_i & reg_mask(i);
    end
    assign regs_o[i] = r_q;
  end

  p_wr_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (wr_addr_i < AW'(NUM_REGS)));
  p_wr_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> busy_i);
endmodule

// File: rtl/vidpre_i2c_regs.sv
module vidpre_i2c_regs
  import vidpre_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h20,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       busy_o,
  output logic [7:0] contrast_o,
  output logic [5:0] bright_o,
  output logic       blank_mode_o,
  output logic [7:0] cut_r_o,
  output logic [7:0] cut_g_o,
  output logic [7:0] cut_b_o,
  output logic [5:0] osd_gain_o,
  output logic       slice_lvl_o,
  output logic [7:0] cut_all_o,
  output logic [7:0] sub_r_o,
  output logic [7:0] sub_g_o,
  output logic [7:0] sub_b_o,
  output logic       det_off_o,
  output logic       src_sel_o,
  output logic       refresh_dis_o
);
  localparam int unsigned AW = 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [NUM_REGS-1:0][DW-1:0] cfg;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_rx_ctrl #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_rx (
    .clk_i, .rst_ni,
    .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .sda_oe_o, .busy_o,
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  ctrl_reg_bank #(.AW(AW)) u_bank (
    .clk_i, .rst_ni, .busy_i(busy_o),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .regs_o(cfg)
  );

  assign contrast_o    = cfg[0];
  assign bright_o      = cfg[1][5:0];
  assign blank_mode_o  = cfg[1][6];
  assign cut_r_o       = cfg[2];
  assign cut_g_o       = cfg[3];
  assign cut_b_o       = cfg[4];
  assign osd_gain_o    = cfg[5][5:0];
  assign slice_lvl_o   = cfg[5][6];
  assign cut_all_o     = cfg[6];
  assign sub_r_o       = cfg[7];
  assign sub_g_o       = cfg[8];
  assign sub_b_o       = cfg[9];
  assign det_off_o     = cfg[10][7];
  assign src_sel_o     = cfg[10][6];
  assign refresh_dis_o = cfg[10][0];

  logic unused_pad_bits;
  assign unused_pad_bits = ^{cfg[1][7], cfg[5][7], cfg[10][5:1]};

  p_dropped_bits_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg[1][7] == 1'b0) && (cfg[5][7] == 1'b0) && (cfg[10][5:1] == 5'd0));
endmodule

// File: tb/vidpre_i2c_regs_tb_top.sv
module vidpre_i2c_regs_tb_top;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, busy;
  logic sda_bus;
  assign sda_bus = m_sda & ~sda_oe;

  logic [7:0] contrast, cut_r, cut_g, cut_b, cut_all, sub_r, sub_g, sub_b;
  logic [5:0] bright, osd_gain;
  logic blank_mode, slice_lvl, det_off, src_sel, refresh_dis;

  vidpre_i2c_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .busy_o(busy),
    .contrast_o(contrast), .bright_o(bright), .blank_mode_o(blank_mode),
    .cut_r_o(cut_r), .cut_g_o(cut_g), .cut_b_o(cut_b),
    .osd_gain_o(osd_gain), .slice_lvl_o(slice_lvl), .cut_all_o(cut_all),
    .sub_r_o(sub_r), .sub_g_o(sub_g), .sub_b_o(sub_b),
    .det_off_o(det_off), .src_sel_o(src_sel), .refresh_dis_o(refresh_dis)
  );

  int checks = 0, errors = 0;
  logic [7:0] model [11];

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] tb_mask(input int i);
    if (i == 1 || i == 5) return 8'h7F;   // R5/R6 layout
    if (i == 10)          return 8'hC1;
    return 8'hFF;
  endfunction

  function automatic logic [7:0] port_reg(input int i);
    case (i)
      0:  return contrast;
      1:  return {1'b0, blank_mode, bright};
      2:  return cut_r;
      3:  return cut_g;
      4:  return cut_b;
      5:  return {1'b0, slice_lvl, osd_gain};
      6:  return cut_all;
      7:  return sub_r;
      8:  return sub_g;
      9:  return sub_b;
      default: return {det_off, src_sel, 5'd0, refresh_dis};
    endcase
  endfunction

  task automatic i2c_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int k = 7; k >= 0; k--) begin
      m_sda = b[k]; tick(Q);
      m_scl = 1'b1; tick(2*Q);
      m_scl = 1'b0; tick(Q);
    end
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    acked = !sda_bus;
    tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 11; i++)
      chk(port_reg(i) == model[i], req, port_reg(i), model[i]);
  endtask

  task automatic write_seq(input logic [7:0] sub, input int n,
                           input logic [7:0] first, input logic [7:0] step);
    bit a;
    logic [7:0] d, p;
    i2c_start();
    send_byte(8'h40, a); chk(a, "R1 address ack", a, 1);
    send_byte(sub, a);   chk(a, "R3 sub-address ack", a, 1);
    p = sub;
    for (int k = 0; k < n; k++) begin
      d = first + 8'(k) * step;
      send_byte(d, a); chk(a, "R3 data ack", a, 1);
      if (p < 8'd11) model[p] = d & tb_mask(int'(p));
      p = p + 8'd1;   // R4 wrap
    end
    i2c_stop();
    tick(4);
  endtask

  task automatic bad_addr(input logic [7:0] adr, input string req);
    bit a;
    i2c_start();
    send_byte(adr, a); chk(!a, req, a, 0);
    send_byte(8'h00, a); chk(!a, req, a, 0);
    send_byte(8'h77, a); chk(!a, req, a, 0);
    send_byte(8'h88, a); chk(!a, req, a, 0);
    i2c_stop();
    tick(4);
    check_all(req);
  endtask

  bit done = 1'b0;

  initial begin
    bit a;
    for (int i = 0; i < 11; i++) model[i] = 8'h00;
    tick(3);
    // R9 reset state
    chk(!busy, "R9 busy", busy, 0);
    chk(!sda_oe, "R9 sda release", sda_oe, 0);
    check_all("R9");
    rst_n = 1'b1;
    tick(5);

    // R5 R6 sweep over sub-addresses 00h..0Fh
    for (int p = 0; p < 3; p++)
      for (int s = 0; s < 16; s++) begin
        logic [7:0] v;
        v = (p == 0) ? 8'hFF : (p == 1) ? 8'h00 : 8'(s * 29 + 51);
        write_seq(8'(s), 1, v, 8'h00);
        check_all("R5 R6 sweep");
      end

    // R4 bursts
    write_seq(8'h00, 11, 8'h11, 8'h13);
    check_all("R4 full burst");
    write_seq(8'h09, 4, 8'hA5, 8'h3C);
    check_all("R4 R6 burst past map");
    write_seq(8'hFE, 3, 8'h5B, 8'h21);
    check_all("R4 wrap");

    // R2 wrong address, R8 read address
    bad_addr(8'h42, "R2 wrong address");
    bad_addr(8'h41, "R8 read address");

    // R7 busy and repeated START
    i2c_start();
    chk(busy, "R7 busy after start", busy, 1);
    send_byte(8'h40, a); chk(a, "R1 ack", a, 1);
    send_byte(8'h03, a);
    send_byte(8'h5C, a); model[3] = 8'h5C;
    i2c_start();
    chk(busy, "R7 busy across repeated start", busy, 1);
    send_byte(8'h40, a); chk(a, "R7 ack after repeated start", a, 1);
    send_byte(8'h07, a);
    send_byte(8'hC3, a); model[7] = 8'hC3;
    chk(busy, "R7 busy before stop", busy, 1);
    i2c_stop();
    tick(4);
    chk(!busy, "R7 busy after stop", busy, 0);
    chk(!sda_oe, "R8 released after stop", sda_oe, 0);
    check_all("R7 repeated start writes");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule